// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block sequences a 16-bit charge-redistribution successive approximation converter. A rising edge on the convert line, seen while the block is idle in acquisition, freezes the sample and starts a run of trials. Each trial word is sent to an external comparator. The block reads back one decision bit per cycle and resolves the code from the most significant bit down to the least. Each trial adds a binary-weighted step that is half the size of the one before it.

The whole sequence runs on the block's own conversion clock, so no serial clock is needed. Once a run has started, it finishes no matter what the convert line does. The finished code is latched into a result register and a one-cycle completion pulse is raised. The block then drops back to acquisition at once, with no pipeline latency, so a serial output stage can read the result. The code is straight binary. It saturates to all ones for an input above full scale and to all zeros for an input below zero.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, done_o, result_o and dac_o are all zero.
- R2: A convert rising edge (conv_i high at a clock edge after being low at the edge before), seen while busy_o is low, makes busy_o high after that edge with dac_o = 0x8000 (only bit 15 set).
- R3: Each trial cycle resolves one bit, from bit 15 down to bit 0. The next trial word keeps every already-decided bit. It clears the bit under trial when cmp_above_i = 1, where 1 means the trial level is above the held input. It sets the next lower bit.
- R4: Once started, a conversion runs to completion and its result is unaffected by any activity on conv_i. Convert edges that arrive while busy_o is high start nothing.
- R5: busy_o stays high for exactly 17 cycles per conversion: 16 trial cycles and one latch cycle.
- R6: done_o is a one-cycle pulse raised on the edge where busy_o falls. result_o changes only on that edge and holds its value until the next pulse.
- R7: result_o is the straight-binary code of the held input. An input above 0xFFFF gives 0xFFFF and an input below zero gives 0x0000.
- R8: dac_o is zero whenever busy_o is low.
- R9: Holding conv_i high after a conversion ends starts no new conversion; a fresh rising edge is needed.
- R10: A rising edge on the edge right after the done edge starts a new conversion, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert line; a rising edge starts a conversion |
| cmp_above_i | input | 1 | Comparator decision: 1 when the trial level is above the held input |
| dac_o | output | 16 | Trial word driven to the capacitor array |
| busy_o | output | 1 | High for the whole conversion |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Latched conversion code |

## Verification
The bench models the comparator as a compare of the trial word against a stored input integer. It runs mid-scale neighbours (0x7FFF, 0x8000), alternating bit patterns, the codes next to the two rails, and exact zero and full scale. Together these show whether each bit's keep-or-clear decision and the all-ones and all-zeros endings are right. Inputs far below zero and above full scale check saturation. A conversion with the convert line toggled every cycle and one with it held high show that edges are ignored during a run and that a level alone does not start one. A start placed on the cycle after completion checks that a new conversion follows with no extra latency.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int unsigned SAR_DEF_BITS = 16;

    typedef enum logic [1:0] {
        PH_ACQ   = 2'd0,
        PH_TRIAL = 2'd1,
        PH_LATCH = 2'd2
    } sar_phase_e;

    typedef struct packed {
        logic load;
        logic step;
        logic latch;
    } sar_strobe_t;

    function automatic logic rise_of(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/sar_conv_edge.sv
module sar_conv_edge
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic conv_i,
    input  logic busy_i,
    output logic start_o
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b0;
        else     conv_q <= conv_i;
    end

    assign start_o = rise_of(conv_i, conv_q) & ~busy_i;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = SAR_DEF_BITS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output sar_phase_e  phase_o,
    output sar_strobe_t strobe_o,
    output logic        busy_o
);
    localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    sar_phase_e    phase;
    logic [CW-1:0] cnt;

    always_comb begin
        strobe_o.load  = start_i && (phase == PH_ACQ);
        strobe_o.step  = (phase == PH_TRIAL);
        strobe_o.latch = (phase == PH_LATCH);
    end

    assign busy_o  = (phase != PH_ACQ);
    assign phase_o = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ACQ;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_ACQ: begin
                    if (start_i) begin
                        phase <= PH_TRIAL;
                        cnt   <= '0;
                    end
                end
                PH_TRIAL: begin
                    if (cnt == LAST) phase <= PH_LATCH;
                    else             cnt   <= cnt + 1'b1;
                end
                PH_LATCH: phase <= PH_ACQ;
                default:  phase <= PH_ACQ;
            endcase
        end
    end

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o) else $error("start lost"); // R2
    AST_LATCH_AFTER_TRIAL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LATCH) |-> ($past(phase) == PH_TRIAL)) else $error("latch order"); // R5
    AST_SINGLE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LATCH) |=> (phase == PH_ACQ)) else $error("latch length"); // R5

endmodule

// File: rtl/sar_conv_reg.sv
module sar_conv_reg
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = SAR_DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  sar_strobe_t     strobe_i,
    input  logic            above_i,
    output logic [BITS-1:0] word_o
);
    logic [BITS-1:0] word, word_n;
    logic [BITS-1:0] probe, probe_n;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        if (i == BITS - 1) begin : g_top
            assign probe_n[i] = 1'b0;
        end else begin : g_low
            assign probe_n[i] = probe[i+1];
        end

        always_comb begin
            if (strobe_i.load)
                word_n[i] = (i == BITS - 1);
            else if (strobe_i.step)
                word_n[i] = probe[i] ? ~above_i : (word[i] | probe_n[i]);
            else
                word_n[i] = word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            probe <= '0;
        end else begin
            word <= word_n;
            if (strobe_i.load)      probe <= {1'b1, {(BITS-1){1'b0}}};
            else if (strobe_i.step) probe <= probe_n;
        end
    end

    assign word_o = word;

    AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(probe)) else $error("probe not one-hot"); // R3
    AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        strobe_i.step |-> ((word & (probe - 1'b1)) == '0)) else $error("low bits set"); // R3
    AST_CLEAR_ON_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (strobe_i.step && above_i) |=> ((word & $past(probe)) == '0)) else $error("bit not cleared"); // R3
    AST_KEEP_ON_BELOW: assert property (@(posedge clk) disable iff (rst)
        (strobe_i.step && !above_i) |=> ((word & $past(probe)) == $past(probe))) else $error("bit not kept"); // R3

endmodule

// File: rtl/sar_conv_out.sv
module sar_conv_out
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = SAR_DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            latch_i,
    input  logic [BITS-1:0] word_i,
    output logic [BITS-1:0] result_o,
    output logic            done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= latch_i;
            if (latch_i) result_o <= word_i;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done too long"); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o)) else $error("result moved"); // R6

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned BITS = SAR_DEF_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            conv_i,
    input  logic            cmp_above_i,
    output logic [BITS-1:0] dac_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [BITS-1:0] result_o
);
    localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

    logic            start;
    logic            busy;
    sar_phase_e      phase;
    sar_strobe_t     strobe;
    logic [BITS-1:0] word;

    sar_conv_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .conv_i  (conv_i),
        .busy_i  (busy),
        .start_o (start)
    );

    sar_conv_seq #(.BITS(BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .phase_o  (phase),
        .strobe_o (strobe),
        .busy_o   (busy)
    );

    sar_conv_reg #(.BITS(BITS)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .above_i  (cmp_above_i),
        .word_o   (word)
    );

    sar_conv_out #(.BITS(BITS)) u_out (
        .clk      (clk),
        .rst      (rst),
        .latch_i  (strobe.latch),
        .word_i   (word),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign busy_o = busy;
    assign dac_o  = (phase == PH_ACQ) ? '0 : word;

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (dac_o == MSB_ONLY)) else $error("first trial wrong"); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))) else $error("done misplaced"); // R5
    AST_RESULT_FROM_TRIAL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o == $past(dac_o))) else $error("result differs"); // R7

endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
    localparam int BITS = 16;
    localparam int FULL = (1 << BITS) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            conv = 1'b0;
    logic            cmp_above;
    logic [BITS-1:0] dac, result;
    logic            busy, done;
    int              in_code = 0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sar_conv_ctrl #(.BITS(BITS)) u_sar_conv_ctrl (
        .clk         (clk),
        .rst         (rst),
        .conv_i      (conv),
        .cmp_above_i (cmp_above),
        .dac_o       (dac),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result)
    );

    // comparator model: trial level above held input
    assign cmp_above = ($signed({16'd0, dac}) > in_code);

    function automatic int clamp(input int v);
        if (v < 0)    return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    // reference model
    bit m_busy = 0, m_done = 0, m_prev = 0;
    int m_cnt = 0, m_code = 0, m_result = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_prev = 0;
            m_cnt = 0; m_code = 0; m_result = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == BITS) begin
                    m_busy = 0; m_done = 1; m_result = m_code;
                end else m_cnt++;
            end else if (conv && !m_prev) begin
                m_busy = 1; m_cnt = 0; m_code = clamp(in_code);
            end
            m_prev = conv;
        end
    end

    function automatic int exp_dac();
        int k;
        if (!m_busy) return 0;
        if (m_cnt == BITS) return m_code;
        k = BITS - 1 - m_cnt;
        return ((m_code >> (k + 1)) << (k + 1)) | (1 << k);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R6 done", int'(done), int'(m_done));
            chk(int'(result) == m_result, "R7 result", int'(result), m_result);
            chk(int'(dac) == exp_dac(), m_busy ? "R3 dac trial" : "R8 dac idle",
                int'(dac), exp_dac());
        end
    end

    // mode 0: single pulse, 1: toggle during run, 2: hold high
    task automatic convert(input int code, input int mode, input string start_tag);
        int nb;
        in_code = code;
        conv = 1'b1;
        nb = 0;
        forever begin
            @(negedge clk);
            if (nb == 0) begin
                chk(busy === 1'b1, start_tag, int'(busy), 1);
                chk(int'(dac) == 32'h8000, {start_tag, " first trial"}, int'(dac), 32'h8000);
            end
            if (!busy) break;
            nb++;
            if (mode == 0) conv = 1'b0;
            else if (mode == 1) conv = ~conv;
        end
        chk(nb == 17, "R5 busy length", nb, 17);
        chk(done === 1'b1, "R6 done at end", int'(done), 1);
        chk(int'(result) == clamp(code), mode == 1 ? "R4 result with toggling" : "R7 code",
            int'(result), clamp(code));
        if (mode != 2) conv = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 status", {busy, done}, 0);
        chk(result == 0 && dac == 0, "R1 data", int'(result | dac), 0);

        convert(32'h1234, 0, "R2 start");
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R6 done single", int'(done), 0);
        convert(32'hA5A5, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(32'h8000, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(32'h7FFF, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(0, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(FULL, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(1, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(FULL - 1, 0, "R2 start");
        repeat (2) @(negedge clk);
        convert(-100, 0, "R7 under range start");
        chk(result == 0, "R7 under range", int'(result), 0);
        repeat (2) @(negedge clk);
        convert(70000, 0, "R7 over range start");
        chk(int'(result) == FULL, "R7 over range", int'(result), FULL);
        repeat (2) @(negedge clk);

        convert(32'h5A3C, 1, "R4 start");
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R4 no restart", int'(busy), 0);

        convert(32'h0F0F, 2, "R9 start");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(busy === 1'b0, "R9 level no start", int'(busy), 0);
        end
        conv = 1'b0;
        @(negedge clk);

        convert(32'h3C3C, 0, "R2 start");
        convert(32'hC3C3, 0, "R10 back to back start");
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule